// File: doc/BRIEF.md
# Hamming Syndrome Decoder and Single-Bit Fixer

This block closes the read path of a 256-byte data chunk protected by a three-byte Hamming code. It receives two code words per chunk: the one recomputed from the data just read and the one kept in the spare area. The two are XORed into a 24-bit syndrome. The number of ones in the syndrome decides the outcome. A clean chunk gives zero ones. A single flipped data bit gives exactly eleven ones. A single flipped bit inside the stored code gives exactly one. Any other weight cannot be repaired.

When a data bit is at fault, the block reports the byte index and the bit position. If the caller asked for a repair with `fix_req`, the block also performs a read-modify-write of that byte through a synchronous memory port that holds the chunk. For every strobe, one `done` pulse carries the status and the location.

Top module: `ecc_syndrome_decoder`

## Requirements
- R1: With `calc_code == stored_code` the status is 0 (clean), and the memory port stays idle.
- R2: Syndrome S = `calc_code ^ stored_code`, where byte k is `S[8k+7:8k]`. Bits 3, 5 and 7 of byte 0 give the reported bit position, with bit 3 as its LSB.
- R3: Bits 1, 3, 5 and 7 of syndrome byte 2 give bits 0 to 3 of the reported byte index, with bit 1 as the LSB.
- R4: Bits 1, 3, 5 and 7 of syndrome byte 1 give bits 4 to 7 of the reported byte index, with bit 1 as the LSB.
- R5: A syndrome with exactly eleven ones gives status 1 (data bit corrected / correctable).
- R6: A syndrome with exactly one one gives status 2 (stored code damaged), and memory is not touched.
- R7: Any other nonzero weight gives status 3 (uncorrectable), and memory is not touched.
- R8: For status 1 with `fix_req` high, the block does the following, then pulses `done`: it reads the byte once, one cycle later writes back the read value XOR (1 << bit), and pulses `done` in the cycle after the write.
- R9: With `fix_req` low, status 1 still reports the location, but the memory port stays idle.
- R10: `done` is a one-cycle pulse. It rises 1 + POP_REG clock edges after the edge that samples `start`, plus 3 edges when a repair is written.
- R11: When status is not 1, `err_byte` and `err_bit` are zero at `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Strobe; codes are sampled when idle |
| fix_req | input | 1 | Request an in-memory repair |
| calc_code | input | 24 | Code recomputed from read data, byte k at [8k+7:8k] |
| stored_code | input | 24 | Code read from the spare area |
| done | output | 1 | One-cycle result pulse |
| status | output | 2 | 0 clean, 1 corrected, 2 code damaged, 3 uncorrectable |
| err_byte | output | 8 | Byte index of the faulty bit |
| err_bit | output | 3 | Bit position of the faulty bit |
| mem_addr | output | 8 | Chunk memory byte address |
| mem_rd | output | 1 | Read enable; data returns one edge later |
| mem_rdata | input | 8 | Read data |
| mem_wr | output | 1 | Write enable |
| mem_wdata | output | 8 | Write data |

## Verification
Without a repair, the result is due 1 + POP_REG edges after the strobe is sampled. A repair adds three edges: a read edge, a modify edge and a write edge. For every operation, the bench works out this cycle from the expected status. At each falling edge up to one cycle beyond that point, it compares `done` against that single expected cycle. It reads status and location only in that cycle, and checks the chunk memory after the pulse. A count of memory accesses kept over the whole operation shows whether the port stayed silent when no repair was due.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;
   localparam int BYTE_W = 8;
   localparam int BIT_W  = 3;

   typedef enum logic [1:0] {
      ST_CLEAN = 2'd0,
      ST_FIXED = 2'd1,
      ST_CODE  = 2'd2,
      ST_MULTI = 2'd3
   } ecc_status_e;

   typedef enum logic [2:0] {
      F_IDLE, F_STAGE, F_EVAL, F_READ, F_MODIFY, F_WRITE
   } ecc_fsm_e;
endpackage

// File: rtl/ecc_syn_popcount.sv
module ecc_syn_popcount #(
   parameter int W     = 24,
   parameter int CNT_W = $clog2(W + 1)
) (
   input  logic [W-1:0]     vec,
   output logic [CNT_W-1:0] ones
);
   always_comb begin
      ones = '0;
      for (int i = 0; i < W; i++)
         ones = ones + CNT_W'(vec[i]);
   end
endmodule

// File: rtl/ecc_syn_classify.sv
module ecc_syn_classify
   import ecc_syn_pkg::*;
#(
   parameter int CODE_BYTES = 3,
   parameter int IDX_W      = 8,
   localparam int SYN_W     = CODE_BYTES * BYTE_W,
   localparam int ROW_PAIRS = IDX_W / 2,
   localparam int LOC_W     = BIT_W + IDX_W,
   localparam int FIX_WT    = LOC_W,
   localparam int CNT_W     = $clog2(SYN_W + 1)
) (
   input  logic [SYN_W-1:0] syn,
   output ecc_status_e      st,
   output logic [IDX_W-1:0] idx,
   output logic [BIT_W-1:0] bitp
);
   logic [CNT_W-1:0] wt;
   logic [LOC_W-1:0] loc;

   ecc_syn_popcount #(.W(SYN_W), .CNT_W(CNT_W)) u_pop (.vec(syn), .ones(wt));

   // Column parity bits: odd bits of syndrome byte 0 starting at bit 3.
   for (genvar j = 0; j < BIT_W; j++) begin : g_col
      assign loc[j] = syn[2*j + 3];
   end
   // Row parity bits: low half from byte 2, high half from byte 1.
   for (genvar j = 0; j < ROW_PAIRS; j++) begin : g_row
      assign loc[BIT_W + j]             = syn[2*BYTE_W + 2*j + 1];
      assign loc[BIT_W + ROW_PAIRS + j] = syn[BYTE_W + 2*j + 1];
   end

   always_comb begin
      st   = ST_MULTI;
      idx  = '0;
      bitp = '0;
      if (wt == '0)
         st = ST_CLEAN;
      else if (wt == CNT_W'(1))
         st = ST_CODE;
      else if (wt == CNT_W'(FIX_WT)) begin
         st   = ST_FIXED;
         idx  = loc[LOC_W-1:BIT_W];
         bitp = loc[BIT_W-1:0];
      end
   end
endmodule

// File: rtl/ecc_syndrome_decoder.sv
module ecc_syndrome_decoder
   import ecc_syn_pkg::*;
#(
   parameter int CODE_BYTES  = 3,
   parameter int CHUNK_BYTES = 256,
   parameter bit POP_REG     = 1'b0,
   localparam int SYN_W      = CODE_BYTES * BYTE_W,
   localparam int IDX_W      = $clog2(CHUNK_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              fix_req,
   input  logic [SYN_W-1:0]  calc_code,
   input  logic [SYN_W-1:0]  stored_code,
   output logic              done,
   output logic [1:0]        status,
   output logic [IDX_W-1:0]  err_byte,
   output logic [BIT_W-1:0]  err_bit,
   output logic [IDX_W-1:0]  mem_addr,
   output logic              mem_rd,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              mem_wr,
   output logic [BYTE_W-1:0] mem_wdata
);
   if (CODE_BYTES != 3) begin : g_bad_code
      $error("code must span three bytes");
   end
   if (IDX_W != 2 * (CODE_BYTES - 1) * 2) begin : g_bad_chunk
      $error("chunk size must match the row parity pairs");
   end

   ecc_fsm_e          state;
   logic [SYN_W-1:0]  syn_q;
   logic              fix_q;
   ecc_status_e       c_st, v_st;
   logic [IDX_W-1:0]  c_idx, v_idx;
   logic [BIT_W-1:0]  c_bit, v_bit;
   logic [BYTE_W-1:0] mask_q;
   logic              done_q, rd_q, wr_q;
   logic [1:0]        status_q;
   logic [IDX_W-1:0]  byte_q, addr_q;
   logic [BIT_W-1:0]  bit_q;
   logic [BYTE_W-1:0] wdata_q;

   ecc_syn_classify #(.CODE_BYTES(CODE_BYTES), .IDX_W(IDX_W)) u_cls (
      .syn(syn_q), .st(c_st), .idx(c_idx), .bitp(c_bit)
   );

   if (POP_REG) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_st  <= ST_CLEAN;
            v_idx <= '0;
            v_bit <= '0;
         end else begin
            v_st  <= c_st;
            v_idx <= c_idx;
            v_bit <= c_bit;
         end
      end
   end else begin : g_direct
      assign v_st  = c_st;
      assign v_idx = c_idx;
      assign v_bit = c_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= F_IDLE;
         syn_q    <= '0;
         fix_q    <= 1'b0;
         mask_q   <= '0;
         done_q   <= 1'b0;
         rd_q     <= 1'b0;
         wr_q     <= 1'b0;
         status_q <= 2'd0;
         byte_q   <= '0;
         bit_q    <= '0;
         addr_q   <= '0;
         wdata_q  <= '0;
      end else begin
         done_q <= 1'b0;
         case (state)
            F_IDLE: if (start) begin
               syn_q <= calc_code ^ stored_code;
               fix_q <= fix_req;
               state <= POP_REG ? F_STAGE : F_EVAL;
            end
            F_STAGE: state <= F_EVAL;
            F_EVAL: begin
               status_q <= v_st;
               byte_q   <= v_idx;
               bit_q    <= v_bit;
               if (v_st == ST_FIXED && fix_q) begin
                  addr_q <= v_idx;
                  mask_q <= BYTE_W'(1) << v_bit;
                  rd_q   <= 1'b1;
                  state  <= F_READ;
               end else begin
                  done_q <= 1'b1;
                  state  <= F_IDLE;
               end
            end
            F_READ: begin
               rd_q  <= 1'b0;
               state <= F_MODIFY;
            end
            F_MODIFY: begin
               wr_q    <= 1'b1;
               wdata_q <= mem_rdata ^ mask_q;
               state   <= F_WRITE;
            end
            F_WRITE: begin
               wr_q   <= 1'b0;
               done_q <= 1'b1;
               state  <= F_IDLE;
            end
            default: state <= F_IDLE;
         endcase
      end
   end

   assign done      = done_q;
   assign status    = status_q;
   assign err_byte  = byte_q;
   assign err_bit   = bit_q;
   assign mem_addr  = addr_q;
   assign mem_rd    = rd_q;
   assign mem_wr    = wr_q;
   assign mem_wdata = wdata_q;
endmodule

// File: rtl/ecc_syndrome_decoder_chk.sv
module ecc_syndrome_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       done,
   input logic [1:0] status,
   input logic [7:0] err_byte,
   input logic [2:0] err_bit,
   input logic       mem_rd,
   input logic       mem_wr
);
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_rd_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);
   assert_rd_wr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
   assert_wr_after_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr) |-> $past(mem_rd, 2));
   assert_wr_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> done);
   assert_loc_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status != 2'd1) |-> (err_byte == 8'd0 && err_bit == 3'd0));
endmodule

bind ecc_syndrome_decoder ecc_syndrome_decoder_chk u_chk (
   .clk(clk), .rst_n(rst_n), .done(done), .status(status),
   .err_byte(err_byte), .err_bit(err_bit), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/sim_ecc_syndrome_decoder.sv
module sim_ecc_syndrome_decoder;
   localparam bit POP_REG = 1'b0;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, fix_req = 1'b0;
   logic [23:0] calc_code = '0, stored_code = '0;
   logic done, mem_rd, mem_wr;
   logic [1:0] status;
   logic [7:0] err_byte, mem_addr, mem_wdata;
   logic [2:0] err_bit;
   logic [7:0] mem_rdata = '0;

   logic [7:0] mem [256];
   logic [7:0] orig [256];
   logic [7:0] work [256];
   logic       poke = 1'b0;
   logic [7:0] poke_a = '0, poke_d = '0;
   int         acc_cnt = 0;
   int         errors = 0, checks = 0;
   bit         finished = 1'b0;

   always #10 clk = ~clk;

   ecc_syndrome_decoder #(.POP_REG(POP_REG)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .fix_req(fix_req),
      .calc_code(calc_code), .stored_code(stored_code), .done(done),
      .status(status), .err_byte(err_byte), .err_bit(err_bit),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata)
   );

   always @(posedge clk) begin
      if (poke) mem[poke_a] <= poke_d;
      else if (mem_wr) mem[mem_addr] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr];
      if (mem_rd || mem_wr) acc_cnt <= acc_cnt + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] ham_code();
      logic [7:0] c0, c1, c2;
      c0 = '0; c1 = '0; c2 = '0;
      for (int i = 0; i < 256; i++) begin
         logic [7:0] b;
         b = work[i];
         c0[2] ^= b[0] ^ b[2] ^ b[4] ^ b[6];
         c0[3] ^= b[1] ^ b[3] ^ b[5] ^ b[7];
         c0[4] ^= b[0] ^ b[1] ^ b[4] ^ b[5];
         c0[5] ^= b[2] ^ b[3] ^ b[6] ^ b[7];
         c0[6] ^= ^b[3:0];
         c0[7] ^= ^b[7:4];
         if (^b) begin
            for (int j = 0; j < 4; j++) begin
               c2[2*j + int'(i[j])]   ^= 1'b1;
               c1[2*j + int'(i[4+j])] ^= 1'b1;
            end
         end
      end
      c0 = ~c0 | 8'h03;
      return {~c2, ~c1, c0};
   endfunction

   task automatic put_byte(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      poke = 1'b1; poke_a = a; poke_d = d;
      @(negedge clk);
      poke = 1'b0;
   endtask

   task automatic run_op(input logic [23:0] calc, input logic [23:0] stored,
                         input bit fix, input logic [1:0] exp_st,
                         input logic [7:0] exp_byte, input logic [2:0] exp_bit,
                         input string req);
      int lat, acc0;
      bit timing_ok;
      lat = 1 + int'(POP_REG) + ((fix && exp_st == 2'd1) ? 3 : 0);
      timing_ok = 1'b1;
      @(negedge clk);
      acc0 = acc_cnt;
      start = 1'b1; fix_req = fix; calc_code = calc; stored_code = stored;
      for (int m = 0; m <= lat + 1; m++) begin
         @(negedge clk);
         start = 1'b0;
         if (done !== (m == lat)) timing_ok = 1'b0;
         if (m == lat) begin
            chk(status == exp_st, {req, " status"}, status, exp_st);
            chk(err_bit == exp_bit, "R2 bit position", err_bit, exp_bit);
            chk(err_byte[3:0] == exp_byte[3:0], "R3 byte index low", err_byte, exp_byte);
            chk(err_byte[7:4] == exp_byte[7:4], "R4 byte index high", err_byte, exp_byte);
         end
      end
      chk(timing_ok, "R10 done timing", lat, lat);
      if (fix && exp_st == 2'd1)
         chk(acc_cnt - acc0 == 2, "R8 one read one write", acc_cnt - acc0, 2);
      else
         chk(acc_cnt == acc0, {req, " memory idle"}, acc_cnt - acc0, 0);
   endtask

   initial begin
      int cyc = 0;
      while (!finished) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      logic [23:0] good;
      for (int i = 0; i < 256; i++) orig[i] = 8'($urandom);
      repeat (3) @(negedge clk);
      chk(!done && !mem_rd && !mem_wr && status == 2'd0, "R10 reset state", {done, mem_rd, mem_wr}, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 256; i++) begin
         work[i] = orig[i];
         put_byte(8'(i), orig[i]);
      end
      good = ham_code();

      // R1: clean chunk
      run_op(good, good, 1'b1, 2'd0, 8'd0, 3'd0, "R1");

      // R5, R8: every single data bit located and repaired in memory
      for (int i = 0; i < 256; i++) begin
         for (int b = 0; b < 8; b++) begin
            logic [7:0] bad;
            bad = orig[i] ^ (8'd1 << b);
            work[i] = bad;
            put_byte(8'(i), bad);
            run_op(ham_code(), good, 1'b1, 2'd1, 8'(i), 3'(b), "R5");
            chk(mem[i] == orig[i], "R8 repaired byte", mem[i], orig[i]);
            work[i] = orig[i];
         end
      end

      // R9: location reported, memory left as is
      for (int k = 0; k < 4; k++) begin
         int i, b;
         logic [7:0] bad;
         i = 37 + k * 61; b = (k * 3) % 8;
         bad = orig[i] ^ (8'd1 << b);
         work[i] = bad;
         put_byte(8'(i), bad);
         run_op(ham_code(), good, 1'b0, 2'd1, 8'(i), 3'(b), "R9");
         chk(mem[i] == bad, "R9 byte untouched", mem[i], bad);
         work[i] = orig[i];
         put_byte(8'(i), orig[i]);
      end

      // R6, R11: each single flipped stored code bit
      for (int k = 0; k < 24; k++)
         run_op(good, good ^ (24'd1 << k), 1'b1, 2'd2, 8'd0, 3'd0, "R6");

      // R7, R11: double data bit errors
      for (int k = 0; k < 6; k++) begin
         int a, c;
         a = (k * 53) % 256; c = (a + 1 + k * 17) % 256;
         work[a] = orig[a] ^ 8'h01;
         work[c] = work[c] ^ (8'h80 >> k);
         run_op(ham_code(), good, 1'b1, 2'd3, 8'd0, 3'd0, "R7");
         chk(mem[a] == orig[a] && mem[c] == orig[c], "R7 memory unchanged", mem[a], orig[a]);
         work[a] = orig[a]; work[c] = orig[c];
      end

      // R1 again on an all-ones chunk code
      for (int i = 0; i < 256; i++) work[i] = 8'hFF;
      good = ham_code();
      run_op(good, good, 1'b0, 2'd0, 8'd0, 3'd0, "R1");

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule